// File: doc/BRIEF.md
# Configuration Data-Port Bridge

This block is the data-window side of a host bridge that reaches configuration space through a pair of registers: one register holds an address and the other acts as a data window. It holds the 32-bit configuration address register. When the host accesses the data window with a byte, a halfword or a word, the block turns that access into one downstream configuration request. The request carries the address, the access size and, for a write, the write data. Read data comes back to the host through the same window. Bit 31 of the address register gates every data-window access.

The host side uses a simple strobe with a wait signal. An access is taken in a cycle where `hst_valid` is high and `hst_wait` is low. The downstream side is a request port with a valid/ready handshake and a response strobe for reads. Only one request can be outstanding at a time. A big-endian host is supported: a static mode input, sampled while reset is held, swaps the byte lanes of halfword and word data.

The controller has three states. IDLE waits for a host access. ISSUE presents the downstream request until it is accepted. WAIT_RSP waits for read data. The transitions are as follows:
- START (IDLE to ISSUE): an enabled data-window access is accepted.
- SENT_WR (ISSUE to IDLE): a write is handed over.
- SENT_RD (ISSUE to WAIT_RSP): a read is handed over.
- RSP (WAIT_RSP to IDLE): the response arrives.

Address-register accesses and disabled data-window accesses never leave IDLE.

Top module: `cfgport_bridge`

## Requirements
- R1: The address register resets to 0. An accepted access with `hst_is_data`=0 writes all 32 bits of it (`hst_write`=1), or reads it back on `hst_rdata` with `hst_rd_done` high in the same cycle (`hst_write`=0).
- R2: While address bit 31 is 0, no downstream request is issued. A data-window write is discarded and the bridge stays idle.
- R3: While address bit 31 is 0, a data-window read completes in its accept cycle. It returns all-ones of its width, zero-extended: 0x000000FF for a byte, 0x0000FFFF for a halfword, 0xFFFFFFFF for a word.
- R4: For byte and halfword accesses, `dn_addr` is the address register ORed with `hst_off`.
- R5: For word accesses, `dn_addr` equals the address register, and `hst_off` is ignored.
- R6: `hst_size` 0, 1 and 2 select byte, halfword and word, and code 3 acts as word. `dn_size` carries 1, 2 or 4 to match.
- R7: In little-endian mode, data sits right-justified. Write data is masked to the access width and is not swapped.
- R8: In big-endian mode, halfword and word data have their byte order reversed within the access width. This applies to both write data and read data. Byte accesses are never swapped.
- R9: Only one request is outstanding at a time. `hst_wait` is high from the cycle after an enabled data-window access is accepted until its completion cycle. While `dn_req_ready` is low, the request is held stable, and accesses presented while `hst_wait` is high are not taken.
- R10: An enabled read completes in the cycle where `dn_rsp_valid` is high during WAIT_RSP, with the response data on `hst_rdata`. An enabled write completes when `dn_req_ready` is seen.
- R11: The byte-order mode is taken from `big_endian_i` only while reset is asserted. Later changes of that input have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian_i | input | 1 | Byte-order mode, sampled during reset |
| hst_valid | input | 1 | Host access strobe |
| hst_is_data | input | 1 | 1 selects the data window, 0 selects the address register |
| hst_write | input | 1 | 1 for a write, 0 for a read |
| hst_size | input | 2 | Access width code |
| hst_off | input | 2 | Byte offset within the data window |
| hst_wdata | input | 32 | Host write data, right-justified |
| hst_wait | output | 1 | Bridge busy; host access not taken |
| hst_rd_done | output | 1 | Read completion strobe |
| hst_rdata | output | 32 | Read data, valid with hst_rd_done |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_write | output | 1 | Request is a write |
| dn_addr | output | 32 | Request address |
| dn_size | output | 3 | Request size in bytes (1, 2 or 4) |
| dn_wdata | output | 32 | Request write data |
| dn_rsp_valid | input | 1 | Read response strobe |
| dn_rsp_data | input | 32 | Read response data |

## Verification
Two events can fall in the same cycle: the completion of an outstanding read and a new host access to the address register. The bench raises a new address-register write in exactly the cycle where it returns the read response. It then judges two things. The read data must be delivered with `hst_wait` still high in that cycle. A later read-back of the address register must show that the colliding write was not taken.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_t;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ISSUE    = 2'd1,
        ST_WAIT_RSP = 2'd2
    } brg_state_t;

    function automatic acc_size_t norm_size(input logic [1:0] code);
        case (code)
            2'd0:    return SZ_BYTE;
            2'd1:    return SZ_HALF;
            default: return SZ_WORD;
        endcase
    endfunction

    function automatic logic [2:0] size_bytes(input acc_size_t sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/cfgport_addr_reg.sv
module cfgport_addr_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_val,
    output logic [ADDR_W-1:0] cur_val
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_val <= '0;
        end else if (wr_en) begin
            cur_val <= wr_val;
        end
    end

endmodule

// File: rtl/cfgport_lane.sv
module cfgport_lane
    import cfgport_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    input  acc_size_t         size,
    input  logic              swap_en,
    output logic [DATA_W-1:0] dout
);

    localparam int NB = DATA_W / 8;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        localparam int HALF_SRC = (i < 2) ? (1 - i) : i;
        localparam int WORD_SRC = NB - 1 - i;
        always_comb begin
            unique case (size)
                SZ_BYTE: dout[8*i +: 8] = (i == 0) ? din[7:0] : 8'h00;
                SZ_HALF: begin
                    if (i < 2) begin
                        dout[8*i +: 8] = swap_en ? din[8*HALF_SRC +: 8] : din[8*i +: 8];
                    end else begin
                        dout[8*i +: 8] = 8'h00;
                    end
                end
                default: dout[8*i +: 8] = swap_en ? din[8*WORD_SRC +: 8] : din[8*i +: 8];
            endcase
        end
    end

endmodule

// File: rtl/cfgport_bridge.sv
module cfgport_bridge
    import cfgport_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian_i,
    input  logic              hst_valid,
    input  logic              hst_is_data,
    input  logic              hst_write,
    input  logic [1:0]        hst_size,
    input  logic [1:0]        hst_off,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic              hst_wait,
    output logic              hst_rd_done,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              dn_req_valid,
    input  logic              dn_req_ready,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [2:0]        dn_size,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic              dn_rsp_valid,
    input  logic [DATA_W-1:0] dn_rsp_data
);

    localparam int EN_BIT = ADDR_W - 1;
    localparam int OFF_W  = 2;

    brg_state_t        state_q, state_d;
    logic              be_q;
    logic [ADDR_W-1:0] cfg_q;
    acc_size_t         host_sz;
    acc_size_t         req_sz_q;
    logic              req_wr_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic [DATA_W-1:0] wr_lane;
    logic [DATA_W-1:0] rd_lane;
    logic [DATA_W-1:0] off_ones;
    logic              accept;
    logic              acc_en;
    logic              start;
    logic              cfg_we;

    assign host_sz = norm_size(hst_size);
    assign accept  = hst_valid && (state_q == ST_IDLE);
    assign acc_en  = cfg_q[EN_BIT];
    assign start   = accept && hst_is_data && acc_en;
    assign cfg_we  = accept && !hst_is_data && hst_write;

    cfgport_addr_reg #(.ADDR_W(ADDR_W)) u_addr_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_val  (hst_wdata[ADDR_W-1:0]),
        .cur_val (cfg_q)
    );

    cfgport_lane #(.DATA_W(DATA_W)) u_wr_lane (
        .din     (hst_wdata),
        .size    (host_sz),
        .swap_en (be_q),
        .dout    (wr_lane)
    );

    cfgport_lane #(.DATA_W(DATA_W)) u_rd_lane (
        .din     (dn_rsp_data),
        .size    (req_sz_q),
        .swap_en (be_q),
        .dout    (rd_lane)
    );

    cfgport_lane #(.DATA_W(DATA_W)) u_ones_lane (
        .din     ({DATA_W{1'b1}}),
        .size    (host_sz),
        .swap_en (1'b0),
        .dout    (off_ones)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            be_q <= big_endian_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_ISSUE;
            ST_ISSUE:    if (dn_req_ready) state_d = req_wr_q ? ST_IDLE : ST_WAIT_RSP;
            ST_WAIT_RSP: if (dn_rsp_valid) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_sz_q    <= SZ_BYTE;
            req_wr_q    <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
        end else if (start) begin
            req_sz_q    <= host_sz;
            req_wr_q    <= hst_write;
            req_addr_q  <= (host_sz == SZ_WORD) ? cfg_q
                         : (cfg_q | {{(ADDR_W-OFF_W){1'b0}}, hst_off});
            req_wdata_q <= hst_write ? wr_lane : '0;
        end
    end

    always_comb begin
        hst_wait     = (state_q != ST_IDLE);
        dn_req_valid = (state_q == ST_ISSUE);
        dn_write     = req_wr_q;
        dn_addr      = req_addr_q;
        dn_size      = size_bytes(req_sz_q);
        dn_wdata     = req_wdata_q;
        hst_rd_done  = 1'b0;
        hst_rdata    = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !hst_write && !hst_is_data) begin
                    hst_rd_done = 1'b1;
                    hst_rdata   = {{(DATA_W-ADDR_W){1'b0}}, cfg_q};
                end else if (accept && !hst_write && !acc_en) begin
                    hst_rd_done = 1'b1;
                    hst_rdata   = off_ones;
                end
            end
            ST_WAIT_RSP: begin
                if (dn_rsp_valid) begin
                    hst_rd_done = 1'b1;
                    hst_rdata   = rd_lane;
                end
            end
            default: ;
        endcase
    end

    AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> dn_addr[EN_BIT]); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_addr) && $stable(dn_wdata) && $stable(dn_size)); // R9

    AST_BUSY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> hst_wait); // R9

    AST_CFG_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        hst_wait |=> $stable(cfg_q)); // R9

    AST_SIZE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> ($countones(dn_size) == 1)); // R6

    AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid && (dn_size == 3'd4) |-> (dn_addr == cfg_q)); // R5

    AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid && dn_write && (dn_size == 3'd1) |-> (dn_wdata[DATA_W-1:8] == '0)); // R8

    AST_BE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(be_q)); // R11

endmodule

// File: tb/cfgport_bridge_tb_top.sv
`timescale 1ns/100ps
module cfgport_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian_i = 1'b0;
    logic        hst_valid = 1'b0;
    logic        hst_is_data = 1'b0;
    logic        hst_write = 1'b0;
    logic [1:0]  hst_size = 2'd0;
    logic [1:0]  hst_off = 2'd0;
    logic [31:0] hst_wdata = '0;
    logic        hst_wait;
    logic        hst_rd_done;
    logic [31:0] hst_rdata;
    logic        dn_req_valid;
    logic        dn_req_ready = 1'b0;
    logic        dn_write;
    logic [31:0] dn_addr;
    logic [2:0]  dn_size;
    logic [31:0] dn_wdata;
    logic        dn_rsp_valid = 1'b0;
    logic [31:0] dn_rsp_data = '0;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] cfg_m = '0;
    bit          be_m  = 1'b0;

    always #2.5 clk = ~clk;

    cfgport_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian_i),
        .hst_valid(hst_valid), .hst_is_data(hst_is_data), .hst_write(hst_write),
        .hst_size(hst_size), .hst_off(hst_off), .hst_wdata(hst_wdata),
        .hst_wait(hst_wait), .hst_rd_done(hst_rd_done), .hst_rdata(hst_rdata),
        .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready), .dn_write(dn_write),
        .dn_addr(dn_addr), .dn_size(dn_size), .dn_wdata(dn_wdata),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_data(dn_rsp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int width_of(input logic [1:0] sz);
        if (sz == 2'd0) return 1;
        if (sz == 2'd1) return 2;
        return 4;
    endfunction

    function automatic logic [31:0] model_lane(input logic [31:0] d, input int n, input bit be);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            if (i < n) r[8*i +: 8] = (be && n > 1) ? d[8*(n-1-i) +: 8] : d[8*i +: 8];
        end
        return r;
    endfunction

    // Every clock: no request may go out with the enable bit clear.
    always @(negedge clk) begin
        if (rst_n && dn_req_valid) chk(dn_addr[31], "R2 per-clock enable", dn_addr, cfg_m);
    end

    task automatic do_reset(input bit be);
        @(negedge clk);
        rst_n = 1'b0;
        big_endian_i = be;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        be_m  = be;
        cfg_m = '0;
        @(negedge clk);
        chk(!hst_wait && !dn_req_valid, "R1 reset idle", {30'd0, hst_wait, dn_req_valid}, 32'd0);
    endtask

    task automatic acc(input bit isd, input bit wr, input logic [1:0] sz, input logic [1:0] off,
                       input logic [31:0] wd, input logic [31:0] rsp, input int rdly, input int sdly,
                       input bit collide, input string tag);
        int          n = width_of(sz);
        bit          en = cfg_m[31];
        logic [31:0] exp_addr = (n == 4) ? cfg_m : (cfg_m | {30'd0, off});
        chk(!hst_wait, {tag, " idle before access"}, {31'd0, hst_wait}, 32'd0);
        hst_valid = 1'b1; hst_is_data = isd; hst_write = wr;
        hst_size = sz; hst_off = off; hst_wdata = wd;
        #1;
        if (!isd && !wr) begin
            chk(hst_rd_done && hst_rdata == cfg_m, {tag, " addr readback"}, hst_rdata, cfg_m);
        end else if (isd && !en && !wr) begin
            chk(hst_rd_done && hst_rdata == model_lane(32'hFFFF_FFFF, n, 1'b0),
                {tag, " disabled read"}, hst_rdata, model_lane(32'hFFFF_FFFF, n, 1'b0));
        end
        @(negedge clk);
        hst_valid = 1'b0;
        if (!isd) begin
            if (wr) cfg_m = wd;
            return;
        end
        if (!en) begin
            chk(!dn_req_valid && !hst_wait, {tag, " disabled no request"}, {30'd0, dn_req_valid, hst_wait}, 32'd0);
            @(negedge clk);
            chk(!dn_req_valid && !hst_wait, {tag, " disabled still idle"}, {30'd0, dn_req_valid, hst_wait}, 32'd0);
            return;
        end
        chk(dn_req_valid && hst_wait, {tag, " request issued"}, {30'd0, dn_req_valid, hst_wait}, 32'd3);
        chk(dn_addr == exp_addr, {tag, " address"}, dn_addr, exp_addr);
        chk(dn_size == 3'(n), {tag, " size code"}, {29'd0, dn_size}, n);
        chk(dn_write == wr, {tag, " direction"}, {31'd0, dn_write}, {31'd0, wr});
        if (wr) chk(dn_wdata == model_lane(wd, n, be_m), {tag, " write data"}, dn_wdata, model_lane(wd, n, be_m));
        for (int k = 0; k < rdly; k++) begin
            @(negedge clk);
            chk(dn_req_valid && dn_addr == exp_addr, {tag, " R9 held"}, dn_addr, exp_addr);
        end
        dn_req_ready = 1'b1;
        @(negedge clk);
        dn_req_ready = 1'b0;
        if (wr) begin
            chk(!hst_wait && !dn_req_valid, {tag, " R10 write done"}, {31'd0, hst_wait}, 32'd0);
            return;
        end
        chk(!dn_req_valid && hst_wait, {tag, " R9 waiting response"}, {30'd0, dn_req_valid, hst_wait}, 32'd1);
        for (int k = 0; k < sdly; k++) begin
            @(negedge clk);
            chk(hst_wait && !hst_rd_done, {tag, " R10 not yet done"}, {31'd0, hst_rd_done}, 32'd0);
        end
        dn_rsp_valid = 1'b1; dn_rsp_data = rsp;
        if (collide) begin
            hst_valid = 1'b1; hst_is_data = 1'b0; hst_write = 1'b1; hst_wdata = 32'hDEAD_0000;
        end
        #1;
        chk(hst_rd_done && hst_rdata == model_lane(rsp, n, be_m), {tag, " R10 read data"},
            hst_rdata, model_lane(rsp, n, be_m));
        if (collide) chk(hst_wait, {tag, " R9 collide stalled"}, {31'd0, hst_wait}, 32'd1);
        @(negedge clk);
        dn_rsp_valid = 1'b0; hst_valid = 1'b0;
        chk(!hst_wait && !hst_rd_done, {tag, " R10 back idle"}, {31'd0, hst_wait}, 32'd0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        summary();
        $finish;
    end

    initial begin
        do_reset(1'b0);
        acc(0, 0, 2'd2, 2'd0, 32'h0, 32'h0, 0, 0, 0, "R1 reset value");
        acc(1, 1, 2'd2, 2'd0, 32'h1234_5678, 32'h0, 0, 0, 0, "R2 write disabled");
        acc(1, 0, 2'd0, 2'd1, 32'h0, 32'h0, 0, 0, 0, "R3 byte off");
        acc(1, 0, 2'd1, 2'd2, 32'h0, 32'h0, 0, 0, 0, "R3 half off");
        acc(1, 0, 2'd2, 2'd0, 32'h0, 32'h0, 0, 0, 0, "R3 word off");
        acc(0, 1, 2'd2, 2'd0, 32'h8000_1204, 32'h0, 0, 0, 0, "R1 write");
        acc(0, 0, 2'd2, 2'd0, 32'h0, 32'h0, 0, 0, 0, "R1 readback");
        acc(1, 1, 2'd0, 2'd3, 32'hFFFF_FFAB, 32'h0, 1, 0, 0, "R4 R7 byte write");
        acc(1, 0, 2'd1, 2'd2, 32'h0, 32'h1234_5678, 2, 3, 0, "R4 R7 half read");
        acc(1, 1, 2'd2, 2'd3, 32'hCAFE_F00D, 32'h0, 0, 0, 0, "R5 word write");
        acc(1, 0, 2'd3, 2'd1, 32'h0, 32'h8765_4321, 0, 1, 0, "R6 code3 read");
        acc(1, 0, 2'd2, 2'd0, 32'h0, 32'hA5A5_0F0F, 1, 0, 1, "R9 collide read");
        acc(0, 0, 2'd2, 2'd0, 32'h0, 32'h0, 0, 0, 0, "R9 collide discarded");
        acc(0, 1, 2'd2, 2'd0, 32'h8000_0001, 32'h0, 0, 0, 0, "R4 low bit set");
        acc(1, 1, 2'd0, 2'd2, 32'h0000_0077, 32'h0, 0, 0, 0, "R4 or merge");
        acc(0, 1, 2'd2, 2'd0, 32'h0000_1200, 32'h0, 0, 0, 0, "R2 disable");
        acc(1, 1, 2'd2, 2'd0, 32'h1111_2222, 32'h0, 0, 0, 0, "R2 write dropped");
        acc(1, 0, 2'd1, 2'd0, 32'h0, 32'h0, 0, 0, 0, "R3 half off again");

        do_reset(1'b1);
        big_endian_i = 1'b0;
        acc(0, 1, 2'd2, 2'd0, 32'h8000_0010, 32'h0, 0, 0, 0, "R11 setup");
        acc(1, 1, 2'd1, 2'd0, 32'h0000_BEEF, 32'h0, 0, 0, 0, "R8 R11 half write swap");
        acc(1, 0, 2'd2, 2'd0, 32'h0, 32'h1122_3344, 0, 2, 0, "R8 word read swap");
        acc(1, 1, 2'd0, 2'd1, 32'h0000_005A, 32'h0, 0, 0, 0, "R8 byte no swap");
        acc(1, 1, 2'd2, 2'd2, 32'h0102_0304, 32'h0, 1, 0, 0, "R8 word write swap");
        acc(1, 0, 2'd1, 2'd2, 32'h0, 32'h0000_AABB, 0, 0, 0, "R8 half read swap");
        acc(1, 0, 2'd0, 2'd3, 32'h0, 32'hFFFF_FF3C, 0, 0, 0, "R8 byte read");

        summary();
        $finish;
    end

endmodule